// File: doc/BRIEF.md
# Square-Wave Half-Period Error Meter

This block watches one digital signal for a trial of fixed length and reports how far each of its level durations falls from a target half-period. A start pulse begins the trial. From then on, a trial tick counter advances once per clock.

Each time the observed signal changes level, the block closes the current interval and measures it. The start of the trial and its end also count as transitions. For each interval, the absolute difference between its length and the target is added to a saturating sum.

When the trial ends, `done_o` rises. At that point the error sum and the interval count are held, so the mean error can be formed downstream. The trial also ends early if the signal switches too often or stays at one level for too long. In that case `abort_o` rises together with `done_o`.

Top module: `halfperiod_err_meter`

## Requirements
- R1: After reset, `done_o`, `abort_o`, `err_sum_o` and `ivl_cnt_o` are all zero, and the block stays idle until `start_i` is sampled high.
- R2: When `start_i` is sampled high, the sum, the count, `done_o` and `abort_o` are cleared and a new trial begins. This applies even while a trial is already running. The clock edge that samples `start_i` is tick 0, and each later edge is the next tick.
- R3: A level change on `sig_i` that is first sampled at the edge of tick n is counted as a transition at tick n+2. This delay comes from two synchronizer flops followed by a compare with the previous synchronized value.
- R4: Tick 0 acts as a virtual transition. The tick equal to `trial_len_i` is the last tick and acts as a transition too. The interval lengths therefore add up to the trial length. A real transition on the last tick closes only one interval.
- R5: For each closed interval of length L, the block adds |L − `target_i`| to `err_sum_o`.
- R6: `err_sum_o` saturates at its all-ones value instead of wrapping.
- R7: `ivl_cnt_o` counts the closed intervals. It grows by at most one per clock.
- R8: If closing an interval makes the count exceed `max_ivl_i`, the trial stops on that tick with `abort_o` set. That interval is included in the sum and the count.
- R9: If the current interval length exceeds `target_i` × `stall_mult_i`, the trial stops on that tick with `abort_o` set. That interval is closed and included.
- R10: `done_o` rises on the clock edge of the final tick. From then until the next start, all outputs hold and changes on `sig_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears the results and begins a trial |
| sig_i | input | 1 | Observed signal, asynchronous |
| target_i | input | CNT_W | Target half-period in ticks |
| trial_len_i | input | CNT_W | Trial length in ticks, at least 1 |
| max_ivl_i | input | IVL_W | Interval count above which the trial aborts |
| stall_mult_i | input | MULT_W | Multiple of the target above which an interval aborts the trial |
| err_sum_o | output | SUM_W | Saturating sum of absolute interval errors |
| ivl_cnt_o | output | IVL_W | Number of closed intervals |
| done_o | output | 1 | Trial finished, results held |
| abort_o | output | 1 | Trial was cut short |

## Verification
The hardest situations to reach are the coincidences: a real transition landing exactly on the last tick, and an abort condition arising on the same tick as an interval close.

The stimulus toggles `sig_i` at tick offsets computed backwards from the known two-cycle detection delay. This places edges precisely on the final tick and on the interval that pushes the count past its limit.

The bench also uses a narrow sum width, so that a long run of moderately wrong intervals drives the sum into saturation within a few hundred cycles.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } hpm_state_e;
endpackage

// File: rtl/hpm_edge_det.sv
module hpm_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  // synchronizer chain: stage 0 samples the pin, each later stage follows
  assign sync_d[0] = sig_i;
  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    assign sync_d[g] = sync_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/hpm_err_accum.sv
module hpm_err_accum #(
  parameter int CNT_W = 24,
  parameter int SUM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] ivl_i,
  input  logic [CNT_W-1:0] target_i,
  output logic [SUM_W-1:0] sum_o
);
  localparam int AW = ((SUM_W > CNT_W) ? SUM_W : CNT_W) + 1;
  localparam logic [AW-1:0] SAT = {{(AW-SUM_W){1'b0}}, {SUM_W{1'b1}}};

  logic [SUM_W-1:0] sum_q, sum_d;
  logic [CNT_W-1:0] diff;
  logic [AW-1:0]    total;

  always_comb begin
    if (ivl_i < target_i) diff = target_i - ivl_i;
    else                  diff = ivl_i - target_i;
    total = AW'(sum_q) + AW'(diff);
    if (clr_i)           sum_d = '0;
    else if (total > SAT) sum_d = {SUM_W{1'b1}};
    else                  sum_d = total[SUM_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sum_q <= '0;
    else if (clr_i || en_i)  sum_q <= sum_d;
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/halfperiod_err_meter.sv
module halfperiod_err_meter
  import hpm_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SUM_W       = 32,
  parameter int IVL_W       = 16,
  parameter int MULT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sig_i,
  input  logic [CNT_W-1:0]  target_i,
  input  logic [CNT_W-1:0]  trial_len_i,
  input  logic [IVL_W-1:0]  max_ivl_i,
  input  logic [MULT_W-1:0] stall_mult_i,
  output logic [SUM_W-1:0]  err_sum_o,
  output logic [IVL_W-1:0]  ivl_cnt_o,
  output logic              done_o,
  output logic              abort_o
);
  localparam int LIM_W = CNT_W + MULT_W;

  hpm_state_e       st_q, st_d;
  logic [CNT_W-1:0] tick_q, tick_d;
  logic [CNT_W-1:0] el_q, el_d;
  logic [IVL_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             done_q, done_d, abort_q, abort_d;

  logic             sig_edge;
  logic [CNT_W:0]   cur;
  logic [LIM_W-1:0] stall_lim;
  logic             last_tick, too_slow, too_fast, close_ivl;
  logic             acc_clr, acc_en;

  hpm_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_i (sig_i),
    .edge_o(sig_edge)
  );

  hpm_err_accum #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (acc_clr),
    .en_i    (acc_en),
    .ivl_i   (cur[CNT_W-1:0]),
    .target_i(target_i),
    .sum_o   (err_sum_o)
  );

  // next-state logic
  always_comb begin
    cur       = {1'b0, el_q} + 1'b1;
    stall_lim = LIM_W'(target_i) * LIM_W'(stall_mult_i);
    last_tick = ({1'b0, tick_q} + 1'b1) == {1'b0, trial_len_i};
    too_slow  = (LIM_W+1)'(cur) > (LIM_W+1)'(stall_lim);
    close_ivl = sig_edge | last_tick | too_slow;
    cnt_inc   = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
    too_fast  = close_ivl && (cnt_inc > max_ivl_i);

    st_d    = st_q;
    tick_d  = tick_q;
    el_d    = el_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    abort_d = abort_q;
    acc_clr = 1'b0;
    acc_en  = 1'b0;

    if (start_i) begin
      st_d    = ST_RUN;
      tick_d  = '0;
      el_d    = '0;
      cnt_d   = '0;
      done_d  = 1'b0;
      abort_d = 1'b0;
      acc_clr = 1'b1;
    end else if (st_q == ST_RUN) begin
      tick_d = tick_q + 1'b1;
      if (close_ivl) begin
        acc_en = 1'b1;
        cnt_d  = cnt_inc;
        el_d   = '0;
      end else begin
        el_d   = cur[CNT_W-1:0];
      end
      if (last_tick || too_slow || too_fast) begin
        st_d    = ST_DONE;
        done_d  = 1'b1;
        abort_d = too_slow | too_fast;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tick_q  <= '0;
      el_q    <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      tick_q  <= tick_d;
      el_q    <= el_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      abort_q <= abort_d;
    end
  end

  assign ivl_cnt_o = cnt_q;
  assign done_o    = done_q;
  assign abort_o   = abort_q;
endmodule

// File: rtl/halfperiod_err_meter_chk.sv
module halfperiod_err_meter_chk #(
  parameter int SUM_W = 32,
  parameter int IVL_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [SUM_W-1:0] err_sum_o,
  input logic [IVL_W-1:0] ivl_cnt_o,
  input logic             done_o,
  input logic             abort_o
);
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (err_sum_o == '0) && (ivl_cnt_o == '0) && !done_o && !abort_o);

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> err_sum_o >= $past(err_sum_o));

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (ivl_cnt_o == $past(ivl_cnt_o)) ||
                 (ivl_cnt_o == $past(ivl_cnt_o) + 1'b1));

  a_r8_abort_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> done_o);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o && $stable(err_sum_o) &&
                             $stable(ivl_cnt_o) && $stable(abort_o));
endmodule

bind halfperiod_err_meter halfperiod_err_meter_chk #(
  .SUM_W(SUM_W),
  .IVL_W(IVL_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .err_sum_o(err_sum_o),
  .ivl_cnt_o(ivl_cnt_o),
  .done_o   (done_o),
  .abort_o  (abort_o)
);

// File: tb/halfperiod_err_meter_tb.sv
module halfperiod_err_meter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int SUM_W = 8;
  localparam int IVL_W = 8;
  localparam int MULT_W = 4;
  localparam int NVEC = 7;

  typedef struct packed {
    int tgt; int trial; int mx; int mult;
    int c0; int per; int ntog;
    int esum; int ecnt; int eab; int etick;
  } vec_t;

  // target, trial, max, mult, first toggle, period, toggles | sum, count, abort, final tick
  localparam vec_t VECS [NVEC] = '{
    '{10, 40, 20,  4,  8, 10,  4,  0,  4, 0,  40},  // exact half-periods, edge on last tick
    '{10, 40, 20,  4,  4,  6,  6, 30,  7, 0,  40},  // short intervals, end closes 4
    '{10, 100, 3,  4,  2,  2, 50, 30,  4, 1,  10},  // too fast
    '{10, 100, 20, 2,  0,  1,  0, 11,  1, 1,  21},  // too slow
    '{10, 30, 20,  4,  0,  1,  0, 20,  1, 0,  30},  // silent, virtual ends only
    '{ 5, 20, 20,  4, 13,  1,  1, 10,  2, 0,  20},  // one edge
    '{ 1, 300, 100, 15, 13, 15, 20, 255, 20, 0, 300} // saturation
  };

  logic clk, rst_n, start_i, sig_i;
  logic [CNT_W-1:0] target_i, trial_len_i;
  logic [IVL_W-1:0] max_ivl_i;
  logic [MULT_W-1:0] stall_mult_i;
  logic [SUM_W-1:0] err_sum_o;
  logic [IVL_W-1:0] ivl_cnt_o;
  logic done_o, abort_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  halfperiod_err_meter #(
    .CNT_W(CNT_W), .SUM_W(SUM_W), .IVL_W(IVL_W), .MULT_W(MULT_W), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sig_i(sig_i),
    .target_i(target_i), .trial_len_i(trial_len_i), .max_ivl_i(max_ivl_i),
    .stall_mult_i(stall_mult_i), .err_sum_o(err_sum_o), .ivl_cnt_o(ivl_cnt_o),
    .done_o(done_o), .abort_o(abort_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
        finish_run();
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // pulse start on the edge that becomes tick 0, toggle per vector, return final tick
  task automatic run_vec(input vec_t v, output int tick);
    target_i = CNT_W'(v.tgt); trial_len_i = CNT_W'(v.trial);
    max_ivl_i = IVL_W'(v.mx); stall_mult_i = MULT_W'(v.mult);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    tick = -1;
    for (int c = 1; c < v.trial + 20; c++) begin
      if (done_o) begin
        tick = c - 1;
        break;
      end
      if (v.ntog > 0 && c >= v.c0 && ((c - v.c0) % v.per) == 0 &&
          ((c - v.c0) / v.per) < v.ntog)
        sig_i = ~sig_i;
      @(negedge clk);
    end
  endtask

  initial begin
    int tk;
    int hs, hc;
    rst_n = 1'b0; start_i = 1'b0; sig_i = 1'b0;
    target_i = '0; trial_len_i = '0; max_ivl_i = '0; stall_mult_i = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    // R1 reset state
    chk("R1 done after reset", int'(done_o), 0);
    chk("R1 abort after reset", int'(abort_o), 0);
    chk("R1 sum after reset", int'(err_sum_o), 0);
    chk("R1 count after reset", int'(ivl_cnt_o), 0);

    for (int i = 0; i < NVEC; i++) begin
      run_vec(VECS[i], tk);
      // R3 latency and R4 virtual ends shape every interval; R5 and R6 the sum
      chk($sformatf("R3 R4 R5 R6 sum vec %0d", i), int'(err_sum_o), VECS[i].esum);
      chk($sformatf("R4 R7 count vec %0d", i), int'(ivl_cnt_o), VECS[i].ecnt);
      chk($sformatf("R8 R9 abort vec %0d", i), int'(abort_o), VECS[i].eab);
      chk($sformatf("R10 final tick vec %0d", i), tk, VECS[i].etick);
      idle(5);
    end

    // R10: after done, toggling the signal changes nothing
    hs = int'(err_sum_o); hc = int'(ivl_cnt_o);
    for (int i = 0; i < 10; i++) begin
      sig_i = ~sig_i;
      @(negedge clk);
    end
    idle(3);
    chk("R10 sum held", int'(err_sum_o), hs);
    chk("R10 count held", int'(ivl_cnt_o), hc);
    chk("R10 done held", int'(done_o), 1);

    // R2: restart in the middle of a trial begins a fresh one
    target_i = 16'd10; trial_len_i = 16'd30; max_ivl_i = 8'd20; stall_mult_i = 4'd4;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    idle(10);
    chk("R2 running before restart", int'(done_o), 0);
    run_vec(VECS[4], tk);
    chk("R2 restart final tick", tk, 30);
    chk("R2 restart sum", int'(err_sum_o), 20);
    chk("R2 restart count", int'(ivl_cnt_o), 1);
    chk("R2 restart abort", int'(abort_o), 0);

    // R1: reset during a trial returns to idle
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    idle(5);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(40);
    chk("R1 idle after reset mid-trial", int'(done_o), 0);
    chk("R1 count after reset mid-trial", int'(ivl_cnt_o), 0);

    finish_run();
  end
endmodule